// File: doc/BRIEF.md
# Camera Frame Capture Controller

This block controls the capture of one frame from a camera that supplies a vertical sync signal and a horizontal reference signal. A host raises a one-cycle request to arm a capture. The capture does not start at once. It starts at the next frame boundary, which is the falling edge of vertical sync. At that boundary the block raises the write-enable of an external frame FIFO. At the boundary after that it lowers write-enable and marks the capture as complete. Pixel data, FIFO storage and sensor setup are outside this block.

The host polls for completion with a one-cycle query strobe. The reply comes back one cycle later. The completion flag can only be read while no capture is in progress, and reading it clears it. In parallel, the block counts rising edges of the horizontal reference in each frame. At every boundary it stores the count of the frame that just ended.

Both camera inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer before its edges are detected.

Top module: `cam_frame_capture`

## Requirements
- R1: After reset is released, `fifo_we_o`, `busy_o`, `done_valid_o`, `line_cnt_o` and `last_lines_o` are all 0. The first query returns `done_o` = 0.
- R2: A one-cycle `cap_req_i` makes `busy_o` read 1 after the next rising clock edge. A request that coincides with a boundary keeps `busy_o` at 1.
- R3: A boundary that sees an armed request drives `fifo_we_o` to 1 and keeps `busy_o` at 1. It also consumes the request, so the following boundary ends the capture unless a new request arrives.
- R4: A boundary with no armed request drives `fifo_we_o` to 0. If `busy_o` was 1, `busy_o` drops to 0 and the completion flag is set. If `busy_o` was 0, the completion flag stays 0.
- R5: Only a falling edge of `vsync_i` counts as a boundary. A rising edge of `vsync_i` changes no output.
- R6: `line_cnt_o` increases by one for each rising edge of `href_i`. A level held high counts only once.
- R7: At each boundary, `last_lines_o` takes the count of the frame that just closed and `line_cnt_o` returns to 0. A rising edge of `href_i` that falls in the same cycle as the boundary is counted into the closing frame.
- R8: The line count saturates at 2^LINE_W-1 (1023 by default) and does not wrap. The stored value is also the saturated value.
- R9: A query strobe gives `done_valid_o` = 1 one cycle later. `done_o` is 0 if `busy_o` was 1 at the time of the query. Otherwise `done_o` equals the completion flag, and the flag is cleared. A completion set in the same cycle as a query made while busy is kept.
- R10: A change on `vsync_i` or `href_i` takes effect at the outputs on the third rising clock edge after the change, not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Camera vertical sync, asynchronous |
| href_i | input | 1 | Camera horizontal reference, asynchronous |
| cap_req_i | input | 1 | One-cycle capture request |
| done_query_i | input | 1 | One-cycle completion query strobe |
| busy_o | output | 1 | A capture is armed or running |
| fifo_we_o | output | 1 | Write-enable to the external frame FIFO |
| done_valid_o | output | 1 | Reply to a query is valid this cycle |
| done_o | output | 1 | Query reply: capture complete |
| line_cnt_o | output | LINE_W | Lines counted so far in the current frame |
| last_lines_o | output | LINE_W | Line count of the previous frame |

## Verification
Two pairs of functions can act in the same cycle:
- The end-of-capture boundary can coincide with a completion query.
- A rising edge of the horizontal reference can coincide with the boundary's line-count snapshot.

The bench provokes both by changing `vsync_i` and `href_i` at the same moment. Both paths have the same synchronizer latency, so their edges line up. The bench also places a query strobe exactly on the clock edge where the boundary is registered. It then checks three things:
- The coincident query returns 0, because the block was still busy.
- A second query returns 1, which shows the completion was not lost.
- The stored line count includes the coincident line, and the live count restarts at 0.

// File: rtl/cam_cap_pkg.sv
`timescale 1ns/1ps
package cam_cap_pkg;
  parameter int unsigned LINE_W_DEF = 10;
  parameter int unsigned SYNC_STAGES_DEF = 2;

  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/cam_sync_edge.sv
`timescale 1ns/1ps
module cam_sync_edge
  import cam_cap_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STAGES_DEF,
  parameter edge_sel_e   SEL    = EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic pulse_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign lvl = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl;
  end

  if (SEL == EDGE_FALL) begin : g_fall
    assign pulse_o = prev_q & ~lvl;
  end else begin : g_rise
    assign pulse_o = ~prev_q & lvl;
  end

  // R6: one edge yields one pulse, never two in a row
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/cam_line_counter.sv
`timescale 1ns/1ps
module cam_line_counter
  import cam_cap_pkg::*;
#(
  parameter int unsigned W = LINE_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         snap_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] last_o
);
  localparam logic [W-1:0] CntMax = '1;

  logic [W-1:0] cnt_q, last_q, cnt_inc;

  assign cnt_inc = (cnt_q == CntMax) ? CntMax : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      last_q <= '0;
    end else if (snap_i) begin
      // a line edge coincident with the boundary closes into the old frame
      last_q <= inc_i ? cnt_inc : cnt_q;
      cnt_q  <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_inc;
    end
  end

  assign cnt_o  = cnt_q;
  assign last_o = last_q;

  a_r7_zero_after_snap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (cnt_o == '0));
  a_r8_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snap_i && cnt_o == CntMax) |=> (cnt_o == CntMax));
  a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!snap_i && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/cam_capture_ctrl.sv
`timescale 1ns/1ps
module cam_capture_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boundary_i,
  input  logic cap_req_i,
  input  logic query_i,
  output logic busy_o,
  output logic we_o,
  output logic done_valid_o,
  output logic done_o
);
  logic req_q, busy_q, done_q, we_q;
  logic done_d;

  always_comb begin
    done_d = done_q;
    if (query_i && !busy_q) done_d = 1'b0;
    if (boundary_i) begin
      if (req_q)       done_d = 1'b0;
      else if (busy_q) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q        <= 1'b0;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      we_q         <= 1'b0;
      done_valid_o <= 1'b0;
      done_o       <= 1'b0;
    end else begin
      done_valid_o <= query_i;
      done_o       <= query_i & ~busy_q & done_q;
      done_q       <= done_d;
      if (boundary_i) we_q <= req_q;
      if (cap_req_i)       req_q <= 1'b1;
      else if (boundary_i) req_q <= 1'b0;
      if (cap_req_i)                              busy_q <= 1'b1;
      else if (boundary_i && !req_q && busy_q)    busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign we_o   = we_q;

  a_r2_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_req_i |=> busy_o);
  a_r3_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && req_q) |=> (we_o && busy_o));
  a_r4_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && !req_q && !cap_req_i) |=> (!we_o && !busy_o));
  a_r5_we_only_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> $stable(we_o));
  a_r9_masked_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (query_i && busy_o) |=> (done_valid_o && !done_o));
endmodule

// File: rtl/cam_frame_capture.sv
`timescale 1ns/1ps
module cam_frame_capture
  import cam_cap_pkg::*;
#(
  parameter int unsigned LINE_W      = LINE_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vsync_i,
  input  logic              href_i,
  input  logic              cap_req_i,
  input  logic              done_query_i,
  output logic              busy_o,
  output logic              fifo_we_o,
  output logic              done_valid_o,
  output logic              done_o,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic [LINE_W-1:0] last_lines_o
);
  localparam int unsigned NumIn = 2;
  localparam edge_sel_e EdgeSel [NumIn] = '{EDGE_FALL, EDGE_RISE};

  logic [NumIn-1:0] raw_in, pulse;
  logic             boundary, line_edge;

  assign raw_in = {href_i, vsync_i};

  for (genvar i = 0; i < NumIn; i++) begin : g_in
    cam_sync_edge #(.STAGES(SYNC_STAGES), .SEL(EdgeSel[i])) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (raw_in[i]),
      .pulse_o(pulse[i])
    );
  end

  assign boundary  = pulse[0];
  assign line_edge = pulse[1];

  cam_capture_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boundary_i  (boundary),
    .cap_req_i   (cap_req_i),
    .query_i     (done_query_i),
    .busy_o      (busy_o),
    .we_o        (fifo_we_o),
    .done_valid_o(done_valid_o),
    .done_o      (done_o)
  );

  cam_line_counter #(.W(LINE_W)) u_lines (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (line_edge),
    .snap_i(boundary),
    .cnt_o (line_cnt_o),
    .last_o(last_lines_o)
  );

  a_r7_snap_only_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary |=> $stable(last_lines_o));
endmodule

// File: tb/cam_frame_capture_tb_top.sv
`timescale 1ns/1ps
module cam_frame_capture_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync = 1'b0, href = 1'b0, cap_req = 1'b0, query = 1'b0;
  logic busy, we, dvalid, done;
  logic [9:0] lcnt, llast;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  cam_frame_capture dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync), .href_i(href),
    .cap_req_i(cap_req), .done_query_i(query), .busy_o(busy),
    .fifo_we_o(we), .done_valid_o(dvalid), .done_o(done),
    .line_cnt_o(lcnt), .last_lines_o(llast)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req();
    cap_req = 1'b1; step(1); cap_req = 1'b0;
  endtask

  task automatic do_query(input string req, input int exp);
    query = 1'b1; step(1); query = 1'b0;
    check(req, "done_valid", int'(dvalid), 1);
    check(req, "done", int'(done), exp);
  endtask

  task automatic lines(input int n);
    for (int k = 0; k < n; k++) begin
      href = 1'b1; step(2); href = 1'b0; step(2);
    end
    step(3);
  endtask

  task automatic boundary();
    vsync = 1'b1; step(4); vsync = 1'b0; step(4);
  endtask

  task automatic t_reset();
    check("R1", "we", int'(we), 0);
    check("R1", "busy", int'(busy), 0);
    check("R1", "done_valid", int'(dvalid), 0);
    check("R1", "line_cnt", int'(lcnt), 0);
    check("R1", "last_lines", int'(llast), 0);
    do_query("R1", 0);
  endtask

  task automatic t_capture();
    pulse_req();
    check("R2", "busy after request", int'(busy), 1);
    do_query("R9", 0);
    lines(5);
    check("R6", "line_cnt", int'(lcnt), 5);
    vsync = 1'b1; step(6);
    check("R5", "we after rising vsync", int'(we), 0);
    check("R5", "line_cnt after rising vsync", int'(lcnt), 5);
    vsync = 1'b0; step(2);
    check("R10", "we before third edge", int'(we), 0);
    step(1);
    check("R10", "we at third edge", int'(we), 1);
    check("R3", "we", int'(we), 1);
    check("R3", "busy", int'(busy), 1);
    check("R7", "last_lines", int'(llast), 5);
    check("R7", "line_cnt cleared", int'(lcnt), 0);
    lines(7);
    href = 1'b1; step(12); href = 1'b0; step(4);
    check("R6", "held href counts once", int'(lcnt), 8);
    boundary();
    check("R4", "we dropped", int'(we), 0);
    check("R4", "busy cleared", int'(busy), 0);
    check("R7", "last_lines", int'(llast), 8);
    do_query("R9", 1);
    do_query("R9", 0);
  endtask

  task automatic t_idle_boundary();
    boundary();
    check("R4", "we idle", int'(we), 0);
    check("R4", "busy idle", int'(busy), 0);
    do_query("R4", 0);
  endtask

  task automatic t_saturate();
    lines(1030);
    check("R8", "line_cnt saturated", int'(lcnt), 1023);
    boundary();
    check("R8", "last_lines saturated", int'(llast), 1023);
    check("R8", "line_cnt cleared", int'(lcnt), 0);
  endtask

  task automatic t_coincide();
    pulse_req();
    boundary();
    check("R3", "we started", int'(we), 1);
    lines(3);
    vsync = 1'b1; step(4);
    vsync = 1'b0; href = 1'b1; step(2);
    query = 1'b1; step(1); query = 1'b0;
    check("R9", "coincident query valid", int'(dvalid), 1);
    check("R9", "coincident query masked", int'(done), 0);
    check("R4", "busy cleared", int'(busy), 0);
    check("R7", "coincident line in closing frame", int'(llast), 4);
    check("R7", "line_cnt restarts", int'(lcnt), 0);
    href = 1'b0; step(2);
    do_query("R9", 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_capture();
    t_idle_boundary();
    t_saturate();
    t_coincide();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule